// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sits beside a small microcontroller core and manages its low-power state. When the core issues a sleep strobe, the controller decides in that same cycle whether the sleep really executes. If any interrupt source has both its flag and its enable set, the sleep is treated as a no-op. Otherwise the controller gates the oscillator, asks for a watchdog clear, and updates two active-low status flags that record power-down and watchdog time-out.

While asleep, the controller watches three wake sources. The first is an enabled pending interrupt, which wakes the core whatever the global interrupt enable says. The second is a watchdog time-out while the watchdog is enabled. The third is the external reset. The external reset forces a full core reset. The other two sources resume execution and raise a one-cycle wake pulse together with the oscillator enable. The global enable only selects between resuming in line and requesting a branch to the fixed interrupt vector once the next instruction has run.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset (`rst_ni` low): `osc_en_o`=1, `status_o`=8'h18 (bit 3 power-down flag = 1, bit 4 time-out flag = 1, all other bits 0), and `wdt_clr_o`, `wake_o`, `vector_o` and `core_rst_o` are all 0.
- R2: A sleep strobe while running, with no enabled pending interrupt and no external reset, enters sleep. On the next cycle `osc_en_o`=0, `wdt_clr_o`=1 for exactly one cycle, `status_o[3]`=0 and `status_o[4]`=1.
- R3: A sleep strobe while running, in a cycle where some bit has both `irq_flag_i` and `irq_en_i` set, is a no-op. `osc_en_o` stays 1, `wdt_clr_o` stays 0 and `status_o` is unchanged.
- R4: An interrupt flag whose enable bit is 0 neither blocks a sleep nor wakes the core.
- R5: While asleep, an enabled pending interrupt wakes the core on the next cycle, whatever `gie_i` is. `wake_o` is 1 for exactly one cycle, and `osc_en_o` returns to 1 in that same cycle.
- R6: `vector_o` is 1 only together with an interrupt-caused `wake_o`, and only when `gie_i` was 1. `vec_addr_o` always carries the vector address 0x0004.
- R7: While asleep, `wdt_to_i` with `wdt_en_i`=1 wakes the core with `vector_o`=0 and clears `status_o[4]`. A time-out with `wdt_en_i`=0 does not wake the core. A time-out while running leaves the status unchanged.
- R8: `ext_rst_i` wins over every other input. On the next cycle `core_rst_o`=1, `osc_en_o`=1, `wake_o`=0, the controller is running, and the status flags are unchanged.
- R9: `wdt_clr_cmd_i` produces `wdt_clr_o`=1 on the next cycle in any state, and changes neither the sleep state nor the flags.
- R10: A sleep strobe received while already asleep is ignored: no watchdog clear, and the oscillator stays off.
- R11: When an interrupt and a watchdog time-out wake the core in the same cycle, the interrupt is taken as the cause. `status_o[4]` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one edge per instruction cycle |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | External reset request |
| sleep_i | input | 1 | Sleep command strobe |
| wdt_clr_cmd_i | input | 1 | Explicit watchdog clear command |
| wdt_to_i | input | 1 | Watchdog time-out |
| wdt_en_i | input | 1 | Watchdog enabled |
| gie_i | input | 1 | Global interrupt enable |
| irq_flag_i | input | NUM_IRQ | Per-source interrupt flags |
| irq_en_i | input | NUM_IRQ | Per-source interrupt enables |
| osc_en_o | output | 1 | Oscillator drive enable |
| wdt_clr_o | output | 1 | Watchdog and postscaler clear pulse |
| status_o | output | 8 | Status byte; bit 3 power-down flag, bit 4 time-out flag (both active low) |
| wake_o | output | 1 | One-cycle wake pulse |
| vector_o | output | 1 | Request to branch to the interrupt vector after the next instruction |
| core_rst_o | output | 1 | Full core reset pulse |
| vec_addr_o | output | VEC_W | Interrupt vector address |

## Verification
The bench builds the block with its defaults: NUM_IRQ=4, VEC_W=13 and VEC_ADDR=4. Four sources are enough to use different bits for the no-op case, the masked-flag case and the wake cases. This shows that pending detection is a per-bit AND of flag and enable, not a test on the flags alone. The cycle-by-cycle table covers the whole sleep/wake cycle, including a sleep strobe that arrives while already asleep. It also covers simultaneous wake causes and an external reset during sleep. Directed steps then apply a power-on reset while asleep and check that both flags are restored.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } pwr_state_e;

  localparam int STAT_W = 8;
  localparam int PD_BIT = 3;
  localparam int TO_BIT = 4;
endpackage

// File: rtl/wake_src.sv
module wake_src #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] irq_flag_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               wdt_to_i,
  input  logic               wdt_en_i,
  output logic               irq_pend_o,
  output logic               wdt_wake_o
);
  logic [NUM_IRQ-1:0] live;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    assign live[g] = irq_flag_i[g] & irq_en_i[g];
  end

  assign irq_pend_o = |live;
  assign wdt_wake_o = wdt_to_i & wdt_en_i;
endmodule

// File: rtl/status_flags.sv
module status_flags
  import sleep_wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_exec_i,
  input  logic              wdt_cause_i,
  output logic [STAT_W-1:0] status_o
);
  logic pd_n_q, to_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_n_q <= 1'b1;
      to_n_q <= 1'b1;
    end else if (sleep_exec_i) begin
      pd_n_q <= 1'b0;
      to_n_q <= 1'b1;
    end else if (wdt_cause_i) begin
      to_n_q <= 1'b0;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[PD_BIT] = pd_n_q;
    status_o[TO_BIT] = to_n_q;
  end

  p_sleep_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_exec_i |=> (!status_o[PD_BIT] && status_o[TO_BIT]));

  p_wdt_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_cause_i |=> !status_o[TO_BIT]);

  p_flags_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_exec_i && !wdt_cause_i) |=> $stable(status_o));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic sleep_i,
  input  logic wdt_clr_cmd_i,
  input  logic irq_pend_i,
  input  logic wdt_wake_i,
  input  logic gie_i,
  output logic sleep_exec_o,
  output logic wdt_cause_o,
  output logic osc_en_o,
  output logic wdt_clr_o,
  output logic wake_o,
  output logic vector_o,
  output logic core_rst_o
);
  pwr_state_e state_q, state_d;
  logic wake_now, irq_wake;
  logic osc_q, wclr_q, wake_q, vec_q, crst_q;

  // sleep decision and pending check share one cycle
  assign sleep_exec_o = (state_q == ST_RUN) && sleep_i && !irq_pend_i && !ext_rst_i;
  assign wake_now     = (state_q == ST_SLEEP) && (irq_pend_i || wdt_wake_i) && !ext_rst_i;
  assign irq_wake     = wake_now && irq_pend_i;
  assign wdt_cause_o  = wake_now && !irq_pend_i && wdt_wake_i;

  always_comb begin
    state_d = state_q;
    if (ext_rst_i)         state_d = ST_RUN;
    else if (sleep_exec_o) state_d = ST_SLEEP;
    else if (wake_now)     state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      osc_q   <= 1'b1;
      wclr_q  <= 1'b0;
      wake_q  <= 1'b0;
      vec_q   <= 1'b0;
      crst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      osc_q   <= (state_d == ST_RUN);
      wclr_q  <= wdt_clr_cmd_i | sleep_exec_o;
      wake_q  <= wake_now;
      vec_q   <= irq_wake & gie_i;
      crst_q  <= ext_rst_i;
    end
  end

  assign osc_en_o   = osc_q;
  assign wdt_clr_o  = wclr_q;
  assign wake_o     = wake_q;
  assign vector_o   = vec_q;
  assign core_rst_o = crst_q;

  p_wake_osc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> osc_en_o);

  p_wake_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !irq_pend_i && !wdt_wake_i) |=> !wake_o);

  p_vec_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> wake_o);

  p_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && sleep_i && !irq_pend_i && !ext_rst_i)
      |=> (!osc_en_o && wdt_clr_o));

  p_noop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && sleep_i && irq_pend_i && !ext_rst_i && !wdt_clr_cmd_i)
      |=> (osc_en_o && !wdt_clr_o));

  p_ext_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (core_rst_o && osc_en_o && !wake_o));

  p_clr_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_cmd_i |=> wdt_clr_o);

  p_sleep_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SLEEP) && !irq_pend_i && !wdt_wake_i && !ext_rst_i && !wdt_clr_cmd_i)
      |=> (!osc_en_o && !wdt_clr_o));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int          NUM_IRQ  = 4,
  parameter int          VEC_W    = 13,
  parameter logic [12:0] VEC_ADDR = 13'h0004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic               sleep_i,
  input  logic               wdt_clr_cmd_i,
  input  logic               wdt_to_i,
  input  logic               wdt_en_i,
  input  logic               gie_i,
  input  logic [NUM_IRQ-1:0] irq_flag_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic               osc_en_o,
  output logic               wdt_clr_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               wake_o,
  output logic               vector_o,
  output logic               core_rst_o,
  output logic [VEC_W-1:0]   vec_addr_o
);
  logic irq_pend, wdt_wake, sleep_exec, wdt_cause;

  wake_src #(.NUM_IRQ(NUM_IRQ)) u_src (
    .irq_flag_i (irq_flag_i),
    .irq_en_i   (irq_en_i),
    .wdt_to_i   (wdt_to_i),
    .wdt_en_i   (wdt_en_i),
    .irq_pend_o (irq_pend),
    .wdt_wake_o (wdt_wake)
  );

  sleep_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ext_rst_i     (ext_rst_i),
    .sleep_i       (sleep_i),
    .wdt_clr_cmd_i (wdt_clr_cmd_i),
    .irq_pend_i    (irq_pend),
    .wdt_wake_i    (wdt_wake),
    .gie_i         (gie_i),
    .sleep_exec_o  (sleep_exec),
    .wdt_cause_o   (wdt_cause),
    .osc_en_o      (osc_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .wake_o        (wake_o),
    .vector_o      (vector_o),
    .core_rst_o    (core_rst_o)
  );

  status_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_exec_i (sleep_exec),
    .wdt_cause_i  (wdt_cause),
    .status_o     (status_o)
  );

  assign vec_addr_o = VEC_W'(VEC_ADDR);
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
  localparam int NV = 22;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_rst, slp, wclr_cmd, wto, wen, gie;
  logic [3:0] flg, ena;
  logic       osc_en, wdt_clr, wake, vec, crst;
  logic [7:0] status;
  logic [12:0] vaddr;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .sleep_i(slp),
    .wdt_clr_cmd_i(wclr_cmd), .wdt_to_i(wto), .wdt_en_i(wen), .gie_i(gie),
    .irq_flag_i(flg), .irq_en_i(ena), .osc_en_o(osc_en), .wdt_clr_o(wdt_clr),
    .status_o(status), .wake_o(wake), .vector_o(vec), .core_rst_o(crst),
    .vec_addr_o(vaddr)
  );

  // row: {ext_rst,sleep,wclr,wto,wen,gie}_{flags}_{enables}_{osc,wclr,pd_n,to_n,wake,vec,crst}
  localparam logic [20:0] VEC [NV] = '{
    21'b000000_0000_0000_1011000, // R1 idle
    21'b010000_0100_0100_1011000, // R3 noop sleep
    21'b010000_0001_0000_0101000, // R2 R4 sleep with masked flag
    21'b010000_0000_0000_0001000, // R10 sleep while asleep
    21'b000000_0001_0000_0001000, // R4 masked flag no wake
    21'b000000_0010_0010_1001100, // R5 wake gie=0
    21'b000000_0000_0000_1001000, // R5 pulse ends
    21'b010000_0000_0000_0101000, // R2
    21'b000001_1000_1000_1001110, // R6 wake with vector
    21'b000000_0000_0000_1001000, // R6
    21'b010000_0000_0000_0101000, // R2
    21'b000100_0000_0000_0001000, // R7 time-out, wdt off
    21'b000111_0000_0000_1000100, // R7 wdt wake
    21'b000000_0000_0000_1000000, // R7
    21'b010000_0000_0000_0101000, // R2 to_n set again
    21'b001000_0000_0000_0101000, // R9 clear cmd asleep
    21'b000110_0001_0001_1001100, // R11 both causes
    21'b010000_0000_0000_0101000, // R2
    21'b100000_0000_0000_1001001, // R8 ext reset asleep
    21'b000000_0000_0000_1001000, // R8
    21'b000110_0000_0000_1001000, // R7 time-out while running
    21'b001000_0000_0000_1101000  // R9 clear cmd running
  };

  string tag [NV];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tag = '{"R1","R3","R2","R10","R4","R5","R5","R2","R6","R6","R2","R7","R7","R7",
            "R2","R9","R11","R2","R8","R8","R7","R9"};
    {ext_rst, slp, wclr_cmd, wto, wen, gie} = '0;
    flg = '0; ena = '0;
    #12;
    // R1 reset state
    chk("R1", {25'd0, osc_en, wdt_clr, wake, vec, crst, 2'd0}, {25'd0, 1'b1, 4'b0, 2'd0});
    chk("R1", {24'd0, status}, 32'h18);
    chk("R6", {19'd0, vaddr}, 32'h4);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {ext_rst, slp, wclr_cmd, wto, wen, gie} = VEC[i][20:15];
      flg = VEC[i][14:11];
      ena = VEC[i][10:7];
      @(negedge clk);
      chk(tag[i], {25'd0, osc_en, wdt_clr, status[3], status[4], wake, vec, crst},
          {25'd0, VEC[i][6:0]});
      chk(tag[i], {29'd0, status[7:5], status[2:0]}, 32'd0);
    end
    {ext_rst, slp, wclr_cmd, wto, wen, gie} = '0;
    flg = '0; ena = '0;
    // R1 power-on reset while asleep restores both flags
    slp = 1'b1;
    @(negedge clk);
    slp = 1'b0;
    chk("R2", {31'd0, osc_en}, 32'd0);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", {24'd0, status}, 32'h18);
    chk("R1", {31'd0, osc_en}, 32'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    // R3 noop leaves pd flag high across several cycles
    slp = 1'b1; flg = 4'b0001; ena = 4'b0001;
    @(negedge clk);
    slp = 1'b0;
    @(negedge clk);
    chk("R3", {23'd0, osc_en, status}, {23'd0, 1'b1, 8'h18});
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule